// File: doc/BRIEF.md
# Calibrated Converter Register Bank

This block is the addressable register file that sits behind the serial port of a sigma-delta converter. A host port supplies a 3-bit register select together with write and read strobes. A calibration sequencer delivers new coefficients, and the conversion pipeline delivers new results. The bank holds five registers: a configuration word, a read-only result word, a fixed identification byte, an offset coefficient and a full-scale coefficient. The result and coefficient registers are `DATA_W` bits wide, with 16 or 24 as the supported values.

The configuration word contains mandatory bit positions. A host write that tries to change one of these bits is silently corrected back to the required value, and a sticky error flag is raised. The burnout, polarity and channel fields drive dedicated output pins. A separate flag marks a channel code that is reserved.

The coefficient pair is protected. A host write to either coefficient lands only while the converter mode reports idle or power-down. In any other mode the write is dropped and a sticky rejection flag is raised. Calibration loads always land, whatever the mode. Reads are registered: a read strobe captures the selected register into `host_rdata` one cycle later.

Top module: `cal_regbank`

## Requirements
- R1: After synchronous reset, the registers hold the following values. Configuration reads 0x0710, the result register reads 0, the ID register reads `ID_VAL` (default 0x5A) and the offset reads midscale (0x8000 when 16 bits wide). The full-scale register reads the top `DATA_W` bits of `FS_FACTORY` (0x54C3 by default). Both sticky flags are 0.
- R2: Only configuration bits 13, 12 and 2:0 take host data. Bits 10:8 and 4 always store 1. Bits 15:14, 11, 7:5 and 3 always store 0.
- R3: A configuration write whose data differs from the mandatory values in any fixed position sets `fixbit_err`. The flag stays set until reset, and a conforming write leaves it unchanged.
- R4: The control outputs follow the configuration register. `burnout_en` is bit 13, `unipolar` is bit 12 and `chan_sel` is bits 2:0. `chan_reserved` is 1 for every channel code except 000, 011, 110 and 111.
- R5: Host writes to select 011 (result) and 100 (ID) change nothing.
- R6: A host write to select 110 (offset) or 111 (full-scale) updates that register when `conv_mode` is 010 (idle) or 011 (power-down).
- R7: In any other mode, a host coefficient write leaves the register unchanged and sets the sticky `wr_reject` flag.
- R8: `cal_zero_ld` loads `cal_coef` into the offset register and `cal_full_ld` loads it into the full-scale register, in any mode. A calibration load wins over a host write to the same register in the same cycle.
- R9: `conv_ld` loads `conv_data` into the result register.
- R10: A `host_rd` strobe puts the selected register on `host_rdata` in the next cycle, with the configuration word zero-extended. Selects 000, 001 and 101 read 0. Without a strobe, `host_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | DATA_W | Write data (configuration uses low 16 bits) |
| conv_mode | input | 3 | Current converter mode (010 idle, 011 power-down) |
| conv_ld | input | 1 | New conversion result valid |
| conv_data | input | DATA_W | Conversion result |
| cal_zero_ld | input | 1 | Zero-scale calibration coefficient valid |
| cal_full_ld | input | 1 | Full-scale calibration coefficient valid |
| cal_coef | input | DATA_W | Calibration coefficient |
| host_rdata | output | DATA_W | Registered read data |
| chan_sel | output | 3 | Selected channel code |
| chan_reserved | output | 1 | Channel code is reserved |
| unipolar | output | 1 | Unipolar coding selected |
| burnout_en | output | 1 | Burnout current enable |
| fixbit_err | output | 1 | Sticky: mandatory bit write attempted |
| wr_reject | output | 1 | Sticky: gated coefficient write dropped |

## Verification
The bench writes configuration patterns that are all-ones, all-zeros and mixed. A design that passed fixed bits through, or masked off a writable bit, would read back a wrong word. A conforming write is made before any violating one, so an error flag that fired on every write is caught. Coefficient writes are tried in idle, power-down and three gated modes. A wrong mode decode either lets a gated write land or drops a legal one. A calibration load that coincides with a host write checks the priority between them. Reads of unused selects, of the read-only registers after writes to them, and of `host_rdata` while no strobe is present expose a mux that leaks data or a read register that is not held.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [2:0] {
        SEL_CFG  = 3'b010,
        SEL_DATA = 3'b011,
        SEL_ID   = 3'b100,
        SEL_OFS  = 3'b110,
        SEL_FS   = 3'b111
    } reg_sel_e;

    localparam logic [2:0] MODE_IDLE  = 3'b010;
    localparam logic [2:0] MODE_PDOWN = 3'b011;

    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] CFG_FIX_MASK = 16'hCFF8;
    localparam logic [CFG_W-1:0] CFG_FIX_VAL  = 16'h0710;
    localparam logic [CFG_W-1:0] CFG_RST      = 16'h0710;

    typedef struct packed {
        logic       burnout;
        logic       unipolar;
        logic [2:0] chan;
    } cfg_ctrl_t;

    function automatic logic [CFG_W-1:0] cfg_fix(input logic [CFG_W-1:0] w);
        return (w & ~CFG_FIX_MASK) | CFG_FIX_VAL;
    endfunction

    function automatic logic cfg_violates(input logic [CFG_W-1:0] w);
        return (w & CFG_FIX_MASK) != CFG_FIX_VAL;
    endfunction

    function automatic logic chan_is_reserved(input logic [2:0] c);
        return !(c == 3'b000 || c == 3'b011 || c == 3'b110 || c == 3'b111);
    endfunction

    function automatic logic coef_gate_open(input logic [2:0] mode);
        return (mode == MODE_IDLE) || (mode == MODE_PDOWN);
    endfunction

endpackage

// File: rtl/crb_cfg_reg.sv
module crb_cfg_reg
    import crb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output cfg_ctrl_t        ctrl,
    output logic             fix_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RST;
            fix_err <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= cfg_fix(wdata);
            if (cfg_violates(wdata))
                fix_err <= 1'b1;
        end
    end

    always_comb begin
        ctrl.burnout  = cfg_q[13];
        ctrl.unipolar = cfg_q[12];
        ctrl.chan     = cfg_q[2:0];
    end

    // R2
    cfg_wr_fields_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_q[13:12] == $past(wdata[13:12])) && (cfg_q[2:0] == $past(wdata[2:0])));

    // R3
    fix_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fix_err |=> fix_err);

endmodule

// File: rtl/crb_coef_reg.sv
module crb_coef_reg #(
    parameter int               DATA_W  = 16,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              gate_open,
    input  logic              cal_ld,
    input  logic [DATA_W-1:0] cal_data,
    output logic [DATA_W-1:0] q,
    output logic              rejected
);

    always_comb rejected = host_wr && !gate_open && !cal_ld;

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (cal_ld)
            q <= cal_data;
        else if (host_wr && gate_open)
            q <= host_wdata;
    end

    // R8
    cal_load_chk: assert property (@(posedge clk) disable iff (rst)
        cal_ld |=> q == $past(cal_data));

    // R7
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !gate_open && !cal_ld) |=> $stable(q));

endmodule

// File: rtl/crb_read_port.sv
module crb_read_port
    import crb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [2:0]        sel,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [DATA_W-1:0] data,
    input  logic [ID_W-1:0]   id,
    input  logic [DATA_W-1:0] ofs,
    input  logic [DATA_W-1:0] fs,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mux_d;

    always_comb begin
        case (sel)
            SEL_CFG:  mux_d = DATA_W'(cfg);
            SEL_DATA: mux_d = data;
            SEL_ID:   mux_d = DATA_W'(id);
            SEL_OFS:  mux_d = ofs;
            SEL_FS:   mux_d = fs;
            default:  mux_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= mux_d;
    end

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/cal_regbank.sv
module cal_regbank
    import crb_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          ID_W       = 8,
    parameter logic [ID_W-1:0] ID_VAL = 8'h5A,
    parameter logic [23:0] FS_FACTORY = 24'h54C300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [2:0]        conv_mode,
    input  logic              conv_ld,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              cal_zero_ld,
    input  logic              cal_full_ld,
    input  logic [DATA_W-1:0] cal_coef,
    output logic [DATA_W-1:0] host_rdata,
    output logic [2:0]        chan_sel,
    output logic              chan_reserved,
    output logic              unipolar,
    output logic              burnout_en,
    output logic              fixbit_err,
    output logic              wr_reject
);

    localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] FS_RST   = FS_FACTORY[23 -: DATA_W];

    logic [CFG_W-1:0]  cfg_q;
    cfg_ctrl_t         ctrl;
    logic [DATA_W-1:0] data_q, ofs_q, fs_q;
    logic              gate_open, ofs_rej, fs_rej;
    logic              wr_cfg, wr_ofs, wr_fs;

    initial begin
        width_chk: assert (DATA_W == 16 || DATA_W == 24);
    end

    always_comb begin
        gate_open = coef_gate_open(conv_mode);
        wr_cfg    = host_wr && (host_sel == SEL_CFG);
        wr_ofs    = host_wr && (host_sel == SEL_OFS);
        wr_fs     = host_wr && (host_sel == SEL_FS);
    end

    crb_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_cfg),
        .wdata   (host_wdata[CFG_W-1:0]),
        .cfg_q   (cfg_q),
        .ctrl    (ctrl),
        .fix_err (fixbit_err)
    );

    crb_coef_reg #(.DATA_W(DATA_W), .RST_VAL(MIDSCALE)) u_ofs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (wr_ofs),
        .host_wdata (host_wdata),
        .gate_open  (gate_open),
        .cal_ld     (cal_zero_ld),
        .cal_data   (cal_coef),
        .q          (ofs_q),
        .rejected   (ofs_rej)
    );

    crb_coef_reg #(.DATA_W(DATA_W), .RST_VAL(FS_RST)) u_fs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (wr_fs),
        .host_wdata (host_wdata),
        .gate_open  (gate_open),
        .cal_ld     (cal_full_ld),
        .cal_data   (cal_coef),
        .q          (fs_q),
        .rejected   (fs_rej)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            wr_reject <= 1'b0;
        end else begin
            if (conv_ld)
                data_q <= conv_data;
            if (ofs_rej || fs_rej)
                wr_reject <= 1'b1;
        end
    end

    crb_read_port #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (host_rd),
        .sel   (host_sel),
        .cfg   (cfg_q),
        .data  (data_q),
        .id    (ID_VAL),
        .ofs   (ofs_q),
        .fs    (fs_q),
        .rdata (host_rdata)
    );

    always_comb begin
        chan_sel      = ctrl.chan;
        unipolar      = ctrl.unipolar;
        burnout_en    = ctrl.burnout;
        chan_reserved = chan_is_reserved(ctrl.chan);
    end

    // R7
    reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_ofs && !cal_zero_ld) || (wr_fs && !cal_full_ld)) && !gate_open |=> wr_reject);

    // R7
    reject_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wr_reject |=> wr_reject);

    // R9
    data_load_chk: assert property (@(posedge clk) disable iff (rst)
        conv_ld |=> data_q == $past(conv_data));

    // R5
    data_ro_chk: assert property (@(posedge clk) disable iff (rst)
        !conv_ld |=> $stable(data_q));

endmodule

// File: tb/tb_cal_regbank.sv
module tb_cal_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   host_sel = '0;
    logic         host_wr = 1'b0, host_rd = 1'b0;
    logic [W-1:0] host_wdata = '0;
    logic [2:0]   conv_mode = '0;
    logic         conv_ld = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         cal_zero_ld = 1'b0, cal_full_ld = 1'b0;
    logic [W-1:0] cal_coef = '0;
    logic [W-1:0] host_rdata;
    logic [2:0]   chan_sel;
    logic         chan_reserved, unipolar, burnout_en, fixbit_err, wr_reject;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_regbank dut (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .conv_mode(conv_mode), .conv_ld(conv_ld), .conv_data(conv_data),
        .cal_zero_ld(cal_zero_ld), .cal_full_ld(cal_full_ld), .cal_coef(cal_coef),
        .host_rdata(host_rdata), .chan_sel(chan_sel), .chan_reserved(chan_reserved),
        .unipolar(unipolar), .burnout_en(burnout_en), .fixbit_err(fixbit_err), .wr_reject(wr_reject)
    );

    // vector: sel[37:35] mode[34:32] wdata[31:16] expected readback[15:0]
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {3'b010, 3'b000, 16'h3007, 16'h3717},
        {3'b010, 3'b000, 16'h0000, 16'h0710},
        {3'b010, 3'b000, 16'hFFFF, 16'h3717},
        {3'b010, 3'b000, 16'h1006, 16'h1716},
        {3'b110, 3'b010, 16'h1234, 16'h1234},
        {3'b111, 3'b011, 16'hBEEF, 16'hBEEF},
        {3'b110, 3'b000, 16'h5555, 16'h1234},
        {3'b111, 3'b001, 16'h0001, 16'hBEEF},
        {3'b011, 3'b010, 16'hAAAA, 16'h0000},
        {3'b100, 3'b010, 16'hFFFF, 16'h005A},
        {3'b000, 3'b010, 16'hFFFF, 16'h0000},
        {3'b110, 3'b100, 16'h7777, 16'h1234}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] sel, input logic [2:0] mode, input logic [W-1:0] d);
        @(negedge clk);
        host_sel = sel; conv_mode = mode; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] sel, output logic [W-1:0] d);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        do_read(3'b010, rd); check("R1 cfg", rd, 16'h0710);
        do_read(3'b011, rd); check("R1 data", rd, 16'h0000);
        do_read(3'b100, rd); check("R1 id", rd, 16'h005A);
        do_read(3'b110, rd); check("R1 offset", rd, 16'h8000);
        do_read(3'b111, rd); check("R1 fullscale", rd, 16'h54C3);
        check("R1 flags", {14'b0, fixbit_err, wr_reject}, 16'h0);

        // R4 and R3: conforming write sets controls, no error
        do_write(3'b010, 3'b000, 16'h2713);
        check("R4 burnout", {15'b0, burnout_en}, 16'h1);
        check("R4 unipolar", {15'b0, unipolar}, 16'h0);
        check("R4 chan", {13'b0, chan_sel}, 16'h3);
        check("R4 reserved 011", {15'b0, chan_reserved}, 16'h0);
        check("R3 no error on conforming write", {15'b0, fixbit_err}, 16'h0);

        // R6: legal write in idle leaves reject clear
        do_write(3'b110, 3'b010, 16'h8000);
        check("R6 no reject in idle", {15'b0, wr_reject}, 16'h0);

        // Vector walk: R2, R5, R6, R7, R10
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][37:35], VEC[i][34:32], VEC[i][31:16]);
            do_read(VEC[i][37:35], rd);
            check($sformatf("R2/R5/R6/R7/R10 vector %0d", i), rd, VEC[i][15:0]);
        end
        check("R3 sticky error set", {15'b0, fixbit_err}, 16'h1);
        check("R7 sticky reject set", {15'b0, wr_reject}, 16'h1);

        // R4 reserved channel codes
        do_write(3'b010, 3'b000, 16'h0715);
        check("R4 reserved 101", {15'b0, chan_reserved}, 16'h1);
        do_write(3'b010, 3'b000, 16'h0716);
        check("R4 reserved 110", {15'b0, chan_reserved}, 16'h0);
        check("R4 unipolar low", {15'b0, unipolar}, 16'h0);

        // R9 conversion load
        @(negedge clk); conv_data = 16'hC0DE; conv_ld = 1'b1;
        @(negedge clk); conv_ld = 1'b0;
        do_read(3'b011, rd); check("R9 data load", rd, 16'hC0DE);

        // R8 zero-scale calibration in a calibration mode
        @(negedge clk); conv_mode = 3'b100; cal_coef = 16'h8123; cal_zero_ld = 1'b1;
        @(negedge clk); cal_zero_ld = 1'b0;
        do_read(3'b110, rd); check("R8 offset cal", rd, 16'h8123);

        // R8 full-scale calibration beats simultaneous host write in idle
        @(negedge clk);
        conv_mode = 3'b010; host_sel = 3'b111; host_wdata = 16'h1111; host_wr = 1'b1;
        cal_coef = 16'h6A6A; cal_full_ld = 1'b1;
        @(negedge clk); host_wr = 1'b0; cal_full_ld = 1'b0;
        do_read(3'b111, rd); check("R8 cal priority", rd, 16'h6A6A);

        // R10 hold without strobe
        @(negedge clk); host_sel = 3'b100;
        repeat (2) @(negedge clk);
        check("R10 hold", host_rdata, 16'h6A6A);

        // R1 reset mid-run clears state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 flags after reset", {14'b0, fixbit_err, wr_reject}, 16'h0);
        do_read(3'b111, rd); check("R1 fullscale after reset", rd, 16'h54C3);
        do_read(3'b110, rd); check("R1 offset after reset", rd, 16'h8000);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule